// File: doc/BRIEF.md
# Serial Bus Node Address Register

This block is a 32-bit control and status register for a serial-bus link controller. It holds the address that the local node has on the bus. Software and link-layer hardware share the register. Software reaches it through a simple synchronous register port, and the register sits at byte offset E8h. The link layer updates it with a bus-reset pulse and with a self-identification-complete strobe. That strobe carries the 6-bit physical node number and the root indication. The link layer also supplies a live cable-power-OK status.

The 16-bit node ID has two parts. The upper part is a 10-bit bus number that software may write. The lower part is the 6-bit physical node number, which only hardware may load. A flag records whether the node number is valid. A bus reset clears the flag, and the next self-ID result sets it again.

The block also drives an interlock for the two asynchronous transmit DMA contexts. While the number is not valid, or while it equals 63, requests to set the run bit of either context are blocked. At power-on the node number starts at 63 and the valid flag starts at 0, so transmit stays locked until the first self-ID completes.

Top module: `node_id_reg`

## Requirements
- R1: After synchronous reset the register reads 0000_FFFFh: bus number all ones, node number 63, and the valid, root and cable-power flags all 0.
- R2: A write at offset E8h loads write-data bits 15..6 into the bus number. A write at any other offset leaves the bus number unchanged.
- R3: Software writes have no effect on bit 31 (valid), bit 30 (root), bit 27 (cable power) or bits 5..0 (node number).
- R4: Bits 29..28 and 26..16 always read as 0.
- R5: A self-ID-complete strobe loads the delivered node number into bits 5..0 and sets bit 31. Both changes are visible on the cycle after the strobe.
- R6: A bus-reset pulse clears bit 31 on the following cycle. The stored node number is kept.
- R7: When a bus reset and a self-ID strobe occur in the same cycle, the bus reset wins. Bit 31 reads 0 afterwards, and the node number is not loaded.
- R8: Bit 30 takes the value of the root input at the self-ID strobe. A bus reset clears it.
- R9: Bit 27 follows the cable-power-OK input with one cycle of delay.
- R10: `tx_block` is 1 whenever the valid flag is 0 or the node number equals 63. Each bit of `tx_run_grant` equals the matching bit of `tx_run_req` when `tx_block` is 0, and is 0 otherwise.
- R11: A read at any offset other than E8h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write enable for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed offset (combinational) |
| bus_reset | input | 1 | Pulse when a bus reset is detected |
| selfid_done | input | 1 | Strobe when self-identification completes |
| selfid_node | input | 6 | Physical node number delivered with the strobe |
| phy_root | input | 1 | PHY reports that it is root |
| cable_pwr_ok | input | 1 | PHY reports that cable power is OK |
| tx_run_req | input | 2 | Run-bit set requests for the two transmit contexts |
| tx_run_grant | output | 2 | Run-bit set requests that are allowed through |
| tx_block | output | 1 | Transmit interlock active |

## Verification
A fault in the valid or node-number state shows on the very next cycle in two places. It shows in the read data at E8h and in `tx_block`, which also blocks or passes `tx_run_req`. If the update priority is wrong, the stale or loaded node number becomes visible on the cycle after a collided bus-reset and self-ID. A bus-number write that leaks into other offsets or fields is caught by the read-back that follows at once. A lost cable-power delay is caught by sampling the read just before and just after the clock edge.

// File: rtl/node_id_pkg.sv
package node_id_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NODE_W     = 6;
    localparam int BUSNUM_W   = 10;
    localparam int N_TX_CTX   = 2;

    localparam logic [ADDR_W-1:0] NID_OFFSET = 8'hE8;

    // bit placement inside the 32-bit word
    localparam int VALID_BIT  = 31;
    localparam int ROOT_BIT   = 30;
    localparam int CPS_BIT    = 27;
    localparam int NODE_LSB   = 0;
    localparam int BUSNUM_LSB = NODE_LSB + NODE_W;
    localparam int BUSNUM_MSB = BUSNUM_LSB + BUSNUM_W - 1;

    localparam logic [NODE_W-1:0]   NODE_UNSET  = '1;
    localparam logic [BUSNUM_W-1:0] BUSNUM_INIT = '1;

    typedef struct packed {
        logic                valid;
        logic                root;
        logic                cps;
        logic [BUSNUM_W-1:0] busnum;
        logic [NODE_W-1:0]   node;
    } nid_fields_t;

    function automatic logic [DATA_W-1:0] pack_word(input nid_fields_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VALID_BIT] = f.valid;
        w[ROOT_BIT]  = f.root;
        w[CPS_BIT]   = f.cps;
        w[BUSNUM_MSB:BUSNUM_LSB] = f.busnum;
        w[BUSNUM_LSB-1:NODE_LSB] = f.node;
        return w;
    endfunction

    function automatic logic node_unusable(input logic valid,
                                           input logic [NODE_W-1:0] node);
        return (!valid) || (node == NODE_UNSET);
    endfunction

endpackage

// File: rtl/nid_link_state.sv
module nid_link_state
    import node_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              selfid_done,
    input  logic [NODE_W-1:0] selfid_node,
    input  logic              phy_root,
    input  logic              cable_pwr_ok,
    output logic              valid_q,
    output logic              root_q,
    output logic              cps_q,
    output logic [NODE_W-1:0] node_q
);

    typedef enum logic [1:0] {
        EV_NONE,
        EV_RESET,
        EV_SELFID
    } link_ev_e;

    link_ev_e ev;

    // bus reset takes priority over a coincident self-ID strobe
    always_comb begin
        if (bus_reset)        ev = EV_RESET;
        else if (selfid_done) ev = EV_SELFID;
        else                  ev = EV_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            root_q  <= 1'b0;
            node_q  <= NODE_UNSET;
        end else begin
            case (ev)
                EV_RESET: begin
                    valid_q <= 1'b0;
                    root_q  <= 1'b0;
                end
                EV_SELFID: begin
                    valid_q <= 1'b1;
                    root_q  <= phy_root;
                    node_q  <= selfid_node;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cps_q <= 1'b0;
        else     cps_q <= cable_pwr_ok;
    end

endmodule

// File: rtl/nid_busnum.sv
module nid_busnum
    import node_id_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hit,
    input  logic [BUSNUM_W-1:0] wr_val,
    output logic [BUSNUM_W-1:0] busnum_q
);

    always_ff @(posedge clk) begin
        if (rst)         busnum_q <= BUSNUM_INIT;
        else if (wr_hit) busnum_q <= wr_val;
    end

endmodule

// File: rtl/nid_tx_gate.sv
module nid_tx_gate
    import node_id_pkg::*;
(
    input  logic                valid,
    input  logic [NODE_W-1:0]   node,
    input  logic [N_TX_CTX-1:0] run_req,
    output logic [N_TX_CTX-1:0] run_grant,
    output logic                block
);

    assign block = node_unusable(valid, node);

    for (genvar i = 0; i < N_TX_CTX; i++) begin : g_ctx
        assign run_grant[i] = run_req[i] & ~block;
    end

endmodule

// File: rtl/node_id_reg.sv
module node_id_reg
    import node_id_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                bus_reset,
    input  logic                selfid_done,
    input  logic [NODE_W-1:0]   selfid_node,
    input  logic                phy_root,
    input  logic                cable_pwr_ok,
    input  logic [N_TX_CTX-1:0] tx_run_req,
    output logic [N_TX_CTX-1:0] tx_run_grant,
    output logic                tx_block
);

    logic                valid_q;
    logic                root_q;
    logic                cps_q;
    logic [NODE_W-1:0]   node_q;
    logic [BUSNUM_W-1:0] busnum_q;
    logic                addr_hit;
    logic                wr_hit;
    nid_fields_t         fields;
    logic                unused_wbits;

    assign addr_hit = (reg_addr == NID_OFFSET);
    assign wr_hit   = reg_wr && addr_hit;

    // only the bus-number slice of the write data is consumed
    assign unused_wbits = ^{reg_wdata[DATA_W-1:BUSNUM_MSB+1],
                            reg_wdata[BUSNUM_LSB-1:0]};

    nid_link_state u_link (
        .clk          (clk),
        .rst          (rst),
        .bus_reset    (bus_reset),
        .selfid_done  (selfid_done),
        .selfid_node  (selfid_node),
        .phy_root     (phy_root),
        .cable_pwr_ok (cable_pwr_ok),
        .valid_q      (valid_q),
        .root_q       (root_q),
        .cps_q        (cps_q),
        .node_q       (node_q)
    );

    nid_busnum u_bus (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (wr_hit),
        .wr_val   (reg_wdata[BUSNUM_MSB:BUSNUM_LSB]),
        .busnum_q (busnum_q)
    );

    nid_tx_gate u_gate (
        .valid     (valid_q),
        .node      (node_q),
        .run_req   (tx_run_req),
        .run_grant (tx_run_grant),
        .block     (tx_block)
    );

    always_comb begin
        fields.valid  = valid_q;
        fields.root   = root_q;
        fields.cps    = cps_q;
        fields.busnum = busnum_q;
        fields.node   = node_q;
        reg_rdata     = addr_hit ? pack_word(fields) : '0;
    end

endmodule

// File: rtl/nid_checker.sv
module nid_checker
    import node_id_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_reset,
    input logic                selfid_done,
    input logic [NODE_W-1:0]   selfid_node,
    input logic                phy_root,
    input logic                cable_pwr_ok,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [BUSNUM_W-1:0] wbus,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                valid_q,
    input logic                root_q,
    input logic                cps_q,
    input logic [NODE_W-1:0]   node_q,
    input logic [BUSNUM_W-1:0] busnum_q,
    input logic [N_TX_CTX-1:0] tx_run_req,
    input logic [N_TX_CTX-1:0] tx_run_grant,
    input logic                tx_block
);

    a_r5_selfid_loads: assert property (@(posedge clk) disable iff (rst)
        (selfid_done && !bus_reset) |=> (valid_q && node_q == $past(selfid_node)));

    a_r6_reset_clears_valid: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !valid_q);

    a_r6_reset_keeps_node: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> $stable(node_q));

    a_r8_root_capture: assert property (@(posedge clk) disable iff (rst)
        (selfid_done && !bus_reset) |=> (root_q == $past(phy_root)));

    a_r8_root_cleared: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !root_q);

    a_r9_cps_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cps_q == $past(cable_pwr_ok)));

    a_r2_busnum_write: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == NID_OFFSET) |=> (busnum_q == $past(wbus)));

    a_r2_busnum_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == NID_OFFSET) |=> $stable(busnum_q));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[29:28] == 2'b00 && reg_rdata[26:16] == 11'h0));

    a_r10_block_grants: assert property (@(posedge clk) disable iff (rst)
        tx_block |-> (tx_run_grant == '0));

    a_r10_no_spurious_grant: assert property (@(posedge clk) disable iff (rst)
        ((tx_run_grant & ~tx_run_req) == '0));

    a_r10_unset_blocks: assert property (@(posedge clk) disable iff (rst)
        (node_q == NODE_UNSET) |-> tx_block);

endmodule

bind node_id_reg nid_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_reset    (bus_reset),
    .selfid_done  (selfid_done),
    .selfid_node  (selfid_node),
    .phy_root     (phy_root),
    .cable_pwr_ok (cable_pwr_ok),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wbus         (reg_wdata[15:6]),
    .reg_rdata    (reg_rdata),
    .valid_q      (valid_q),
    .root_q       (root_q),
    .cps_q        (cps_q),
    .node_q       (node_q),
    .busnum_q     (busnum_q),
    .tx_run_req   (tx_run_req),
    .tx_run_grant (tx_run_grant),
    .tx_block     (tx_block)
);

// File: tb/tb_node_id_reg.sv
module tb_node_id_reg;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        bus_reset;
    logic        selfid_done;
    logic [5:0]  selfid_node;
    logic        phy_root;
    logic        cable_pwr_ok;
    logic [1:0]  tx_run_req;
    logic [1:0]  tx_run_grant;
    logic        tx_block;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    node_id_reg dut (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .bus_reset    (bus_reset),
        .selfid_done  (selfid_done),
        .selfid_node  (selfid_node),
        .phy_root     (phy_root),
        .cable_pwr_ok (cable_pwr_ok),
        .tx_run_req   (tx_run_req),
        .tx_run_grant (tx_run_grant),
        .tx_block     (tx_block)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic write_at(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic selfid(input logic [5:0] n, input logic root, input logic with_reset);
        @(negedge clk);
        selfid_node = n; phy_root = root; selfid_done = 1'b1; bus_reset = with_reset;
        @(negedge clk);
        selfid_done = 1'b0; bus_reset = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        read_at(8'hE8, d);
        check("R1 reset value", d, 32'h0000_FFFF);
        check("R10 block after reset", {31'h0, tx_block}, 32'h1);
        read_at(8'hE4, d);
        check("R11 other offset reads zero", d, 32'h0);
    endtask

    task automatic t_busnum();
        logic [31:0] d;
        write_at(8'hE8, 32'h0000_5540);
        read_at(8'hE8, d);
        check("R2 bus number write", d, 32'h0000_557F);
        write_at(8'hEC, 32'h0000_0000);
        read_at(8'hE8, d);
        check("R2 write other offset ignored", d, 32'h0000_557F);
        write_at(8'hE8, 32'hFFFF_0000);
        read_at(8'hE8, d);
        check("R3 upper bits and node not writable", d, 32'h0000_003F);
        check("R4 reserved bits zero", d & 32'h37FF_0000, 32'h0);
        write_at(8'hE8, 32'h0000_FFC0);
        read_at(8'hE8, d);
        check("R2 bus number restore", d, 32'h0000_FFFF);
    endtask

    task automatic t_selfid();
        logic [31:0] d;
        @(negedge clk);
        cable_pwr_ok = 1'b1;
        tx_run_req = 2'b11;
        selfid(6'd5, 1'b1, 1'b0);
        read_at(8'hE8, d);
        check("R5/R8/R9 self-ID loads word", d, 32'hC800_FFC5);
        check("R10 unblocked after self-ID", {31'h0, tx_block}, 32'h0);
        check("R10 grants pass", {30'h0, tx_run_grant}, 32'h3);
    endtask

    task automatic t_busreset();
        logic [31:0] d;
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        read_at(8'hE8, d);
        check("R6/R8 bus reset clears valid and root, keeps node", d, 32'h0800_FFC5);
        check("R10 blocked when invalid", {31'h0, tx_block}, 32'h1);
        check("R10 grants gated", {30'h0, tx_run_grant}, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        selfid(6'd9, 1'b1, 1'b1);
        read_at(8'hE8, d);
        check("R7 bus reset wins over self-ID", d, 32'h0800_FFC5);
    endtask

    task automatic t_node63();
        logic [31:0] d;
        selfid(6'd63, 1'b0, 1'b0);
        read_at(8'hE8, d);
        check("R5 node 63 loaded valid", d, 32'h8800_FFFF);
        check("R10 node 63 blocks", {31'h0, tx_block}, 32'h1);
        check("R10 node 63 grants gated", {30'h0, tx_run_grant}, 32'h0);
        selfid(6'd62, 1'b0, 1'b0);
        tx_run_req = 2'b01;
        read_at(8'hE8, d);
        check("R10 single grant passes", {30'h0, tx_run_grant}, 32'h1);
    endtask

    task automatic t_cps();
        logic [31:0] d;
        @(negedge clk);
        cable_pwr_ok = 1'b0;
        reg_addr = 8'hE8;
        #1 d = reg_rdata;
        check("R9 cable power before edge", {31'h0, d[27]}, 32'h1);
        @(negedge clk);
        #1 d = reg_rdata;
        check("R9 cable power after edge", {31'h0, d[27]}, 32'h0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; reg_addr = 8'h0; reg_wr = 1'b0; reg_wdata = '0;
        bus_reset = 1'b0; selfid_done = 1'b0; selfid_node = '0;
        phy_root = 1'b0; cable_pwr_ok = 1'b0; tx_run_req = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_busnum();
        t_selfid();
        t_busreset();
        t_collide();
        t_node63();
        t_cps();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

endmodule